// File: doc/BRIEF.md
# Field-Envelope Command Frame Receiver

This block listens for commands that a reader sends by dipping the strength of the carrier field. A comparator gives one bit per carrier clock (high field or low field). The block also gets a rate select that sets a bit period of 64 or 32 carrier clocks. While the tag is in read mode, the block samples the field once per bit period. It waits for a synchronisation envelope: a run of high samples, then a dip, then a return to high. After that envelope it hunts for a start bit by sampling eight times per bit period. It then shifts in NRZ bits, most significant bit first.

While a command is arriving, the block drives the modulator load request. The load stays connected while the block waits for a start bit. During each received bit the load is released for the first half and connected for the second half, so the supply keeps charging. The first byte is decoded into one of five commands. A write command goes on to collect three more bytes, each framed by a start bit and a stop bit. The result is reported as a one-cycle command strobe that carries a kind code and a 32-bit frame. Malformed traffic gives a one-cycle abort strobe. An expired wait gives a one-cycle timeout strobe.

Command detection is blanked for one full 128-bit readout cycle after reset, after a reset command, and after the post-envelope watchdog expires.

Top module: `envcmd_rx`

## Requirements
- R1: After reset, mod_on is low and no strobe fires. A complete, well-formed envelope and command sent within the first 128 bit periods produce no strobe.
- R2: The field is sampled once per bit period in read mode. The start-bit search is armed only by at least 4 consecutive high samples, then one or more low samples, then a high sample. A run of fewer than 4 high samples before the dip arms nothing.
- R3: Once armed, if no start bit is found within 8 bit periods, timeout pulses for one cycle and the block returns to read mode.
- R4: The start bit is accepted when three consecutive samples, taken at one-eighth bit-period spacing, are all low.
- R5: mod_on is high while the block waits for a start bit. During each received bit, mod_on is low for the first half and high for the second half. Each bit value is taken at the end of the high half. mod_on is low in read mode.
- R6: Received bits are NRZ (high field = 1, low field = 0) and arrive MSB first. For a simple command, cmd_frame[31:24] holds the received byte and the rest of cmd_frame is zero.
- R7: The first byte is decoded as follows. 0xA0 gives kind 1 (reset). 0xA5 gives kind 2 (read fixed ID). 0xF0 gives kind 3 (read configuration). 0xD3 gives kind 4 (write configuration). Any byte 0xC0 to 0xCF gives kind 5 (write word). The command is reported by a one-cycle cmd_valid strobe together with cmd_kind.
- R8: Any other first byte gives a one-cycle abort strobe and no cmd_valid.
- R9: A write command collects four bytes, each sent as a 0 start bit, eight data bits and a 1 stop bit. cmd_frame then holds the first byte in bits 31:24 and the last byte in bits 7:0.
- R10: After each byte of a write command, mod_on is low for half a bit period. The block then waits for the next start bit for at most 2 bit periods. If none comes, timeout pulses, the block returns to read mode, and detection is not blanked.
- R11: A reset command, and an expired post-envelope watchdog, each blank command detection for 128 bit periods. After that, commands are accepted again.
- R12: half_rate = 1 selects 32 carrier clocks per bit; half_rate = 0 selects 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-derived clock, one edge per field period |
| rst_n | input | 1 | Active-low reset |
| half_rate | input | 1 | 1: 32 clocks per bit, 0: 64 clocks per bit |
| fld_hi | input | 1 | Field comparator: 1 = high field |
| mod_on | output | 1 | Modulator load request, 1 = load connected |
| cmd_valid | output | 1 | One-cycle strobe for a recognised command |
| cmd_kind | output | 3 | Command kind code, valid with cmd_valid |
| cmd_frame | output | 32 | Received frame, valid with cmd_valid |
| abort | output | 1 | One-cycle strobe for an unknown first byte |
| timeout | output | 1 | One-cycle strobe for an expired wait |

## Verification
Several properties are checked by the assertions on every cycle:
- At most one of the three strobes fires in any cycle.
- The wait counter stays below its active limit.
- Arming never happens while detection is blanked.
- Reception begins only after a low field sample.
- Each bit is taken while the load is connected.
- A write-word report always carries the write opcode nibble.

Other behaviour can only be shown by the bench's scenarios:
- How each byte value decodes.
- MSB-first frame assembly.
- The exact count of modulator pulses in a byte.
- Rejection of a short high run.
- Where each blanking window starts and ends.
- The difference between the two timeout kinds.
- Operation at both bit rates.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    typedef enum logic [2:0] {
        KIND_NONE       = 3'd0,
        KIND_RESET      = 3'd1,
        KIND_READ_ID    = 3'd2,
        KIND_READ_CFG   = 3'd3,
        KIND_WRITE_CFG  = 3'd4,
        KIND_WRITE_WORD = 3'd5
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_READ = 2'd0,
        ST_WAIT = 2'd1,
        ST_RX   = 2'd2,
        ST_GAP  = 2'd3
    } rx_state_e;

    localparam logic [7:0] OP_RESET     = 8'hA0;
    localparam logic [7:0] OP_READ_ID   = 8'hA5;
    localparam logic [7:0] OP_READ_CFG  = 8'hF0;
    localparam logic [7:0] OP_WRITE_CFG = 8'hD3;
    localparam logic [3:0] OP_WRITE_HI  = 4'b1100;

    function automatic cmd_kind_e decode_first(input logic [7:0] b);
        cmd_kind_e k;
        k = KIND_NONE;
        if (b == OP_RESET)                 k = KIND_RESET;
        else if (b == OP_READ_ID)          k = KIND_READ_ID;
        else if (b == OP_READ_CFG)         k = KIND_READ_CFG;
        else if (b == OP_WRITE_CFG)        k = KIND_WRITE_CFG;
        else if (b[7:4] == OP_WRITE_HI)    k = KIND_WRITE_WORD;
        return k;
    endfunction

endpackage

// File: rtl/fcr_timebase.sv
module fcr_timebase #(
    parameter int BIT_SLOW = 64,
    parameter int BIT_FAST = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_rate,
    input  logic restart,
    output logic bit_end,
    output logic eighth_tick,
    output logic half_end,
    output logic second_half
);
    localparam int PW = $clog2(BIT_SLOW);

    logic [PW-1:0] phase_d, phase_q;
    logic [PW:0]   bit_len, half_len, eighth_len, ph_ext;

    always_comb begin
        bit_len     = half_rate ? (PW+1)'(BIT_FAST) : (PW+1)'(BIT_SLOW);
        half_len    = bit_len >> 1;
        eighth_len  = bit_len >> 3;
        ph_ext      = {1'b0, phase_q};
        bit_end     = ph_ext >= (bit_len - 1'b1);
        half_end    = ph_ext == (half_len - 1'b1);
        second_half = ph_ext >= half_len;
        eighth_tick = (ph_ext & (eighth_len - 1'b1)) == (eighth_len - 1'b1);
        if (restart || bit_end) phase_d = '0;
        else                    phase_d = phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    AST_PHASE_IN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(half_rate) == half_rate) |-> (ph_ext < bit_len)) else $error("phase out of bit"); // R12

endmodule

// File: rtl/fcr_envelope.sv
module fcr_envelope #(
    parameter int HI_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample_en,
    input  logic fld_hi,
    output logic arm
);
    localparam int HW = $clog2(HI_MIN + 1);

    typedef struct packed {
        logic [HW-1:0] hi_cnt;
        logic          lo_seen;
    } env_t;

    env_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        arm = sample_en && e_q.lo_seen && fld_hi && !clear;
        if (clear) begin
            e_d = '0;
        end else if (sample_en) begin
            if (e_q.lo_seen) begin
                if (fld_hi) e_d = '0;
            end else if (fld_hi) begin
                if (e_q.hi_cnt != HW'(HI_MIN)) e_d.hi_cnt = e_q.hi_cnt + 1'b1;
            end else if (e_q.hi_cnt == HW'(HI_MIN)) begin
                e_d.lo_seen = 1'b1;
            end else begin
                e_d.hi_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    AST_DIP_AFTER_HIGHS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_q.lo_seen) |-> ($past(e_q.hi_cnt) == HW'(HI_MIN))) else $error("dip without highs"); // R2

endmodule

// File: rtl/fcr_blanker.sv
module fcr_blanker #(
    parameter int SPAN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic active
);
    localparam int CW = $clog2(SPAN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        active = cnt_q != '0;
        cnt_d  = cnt_q;
        if (start)                cnt_d = CW'(SPAN);
        else if (tick && active)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CW'(SPAN);
        else        cnt_q <= cnt_d;
    end

    AST_BLANK_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(tick)) else $error("blank ended off tick"); // R11

endmodule

// File: rtl/envcmd_rx.sv
module envcmd_rx
    import fcr_pkg::*;
#(
    parameter int BIT_SLOW       = 64,
    parameter int BIT_FAST       = 32,
    parameter int SYNC_HI_MIN    = 4,
    parameter int SYNC_WDOG_BITS = 8,
    parameter int GAP_WDOG_BITS  = 2,
    parameter int BLANK_BITS     = 128,
    parameter int START_LOWS     = 3,
    parameter int FRAME_BYTES    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        half_rate,
    input  logic        fld_hi,
    output logic        mod_on,
    output logic        cmd_valid,
    output logic [2:0]  cmd_kind,
    output logic [31:0] cmd_frame,
    output logic        abort,
    output logic        timeout
);
    localparam int FRAME_W = FRAME_BYTES * 8;
    localparam int WD_W    = $clog2(SYNC_WDOG_BITS + 1);
    localparam int LR_W    = $clog2(START_LOWS + 1);
    localparam int BYTE_W  = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;

    typedef struct packed {
        rx_state_e          state;
        logic               from_read;
        logic [WD_W-1:0]    wdog;
        logic [LR_W-1:0]    low_run;
        logic [2:0]         bit_cnt;
        logic [BYTE_W-1:0]  byte_cnt;
        logic [FRAME_W-1:0] shreg;
        cmd_kind_e          pend_kind;
        logic               cmd_valid;
        cmd_kind_e          cmd_kind;
        logic [FRAME_W-1:0] frame;
        logic               abort;
        logic               timeout;
    } regs_t;

    regs_t r_d, r_q;

    logic tb_restart, tb_bit_end, tb_eighth, tb_half_end, tb_second_half;
    logic env_arm, env_clear, blank_start, blank_active;
    logic [WD_W-1:0]    wd_lim;
    logic [7:0]         nb;
    logic [FRAME_W-1:0] nf;
    cmd_kind_e          k;

    fcr_timebase #(.BIT_SLOW(BIT_SLOW), .BIT_FAST(BIT_FAST)) i_timebase (
        .clk(clk), .rst_n(rst_n), .half_rate(half_rate), .restart(tb_restart),
        .bit_end(tb_bit_end), .eighth_tick(tb_eighth), .half_end(tb_half_end),
        .second_half(tb_second_half)
    );

    assign env_clear = (r_q.state != ST_READ) || blank_active;

    fcr_envelope #(.HI_MIN(SYNC_HI_MIN)) i_envelope (
        .clk(clk), .rst_n(rst_n), .clear(env_clear), .sample_en(tb_bit_end),
        .fld_hi(fld_hi), .arm(env_arm)
    );

    fcr_blanker #(.SPAN(BLANK_BITS)) i_blanker (
        .clk(clk), .rst_n(rst_n), .start(blank_start), .tick(tb_bit_end),
        .active(blank_active)
    );

    always_comb begin
        r_d           = r_q;
        r_d.cmd_valid = 1'b0;
        r_d.abort     = 1'b0;
        r_d.timeout   = 1'b0;
        tb_restart    = 1'b0;
        blank_start   = 1'b0;
        wd_lim = r_q.from_read ? WD_W'(SYNC_WDOG_BITS) : WD_W'(GAP_WDOG_BITS);
        nb     = {r_q.shreg[6:0], fld_hi};
        nf     = {r_q.shreg[FRAME_W-2:0], fld_hi};
        k      = decode_first(nb);
        case (r_q.state)
            ST_READ: begin
                if (env_arm) begin
                    r_d.state     = ST_WAIT;
                    r_d.from_read = 1'b1;
                    r_d.wdog      = '0;
                    r_d.low_run   = '0;
                    r_d.shreg     = '0;
                    r_d.byte_cnt  = '0;
                    r_d.bit_cnt   = '0;
                    tb_restart    = 1'b1;
                end
            end
            ST_WAIT: begin
                if (tb_eighth && !fld_hi && r_q.low_run == LR_W'(START_LOWS - 1)) begin
                    r_d.state   = ST_RX;
                    r_d.bit_cnt = '0;
                    r_d.low_run = '0;
                    tb_restart  = 1'b1;
                end else begin
                    if (tb_eighth) r_d.low_run = fld_hi ? '0 : r_q.low_run + 1'b1;
                    if (tb_bit_end) begin
                        if (r_q.wdog == wd_lim - 1'b1) begin
                            r_d.timeout = 1'b1;
                            r_d.state   = ST_READ;
                            blank_start = r_q.from_read;
                        end else begin
                            r_d.wdog = r_q.wdog + 1'b1;
                        end
                    end
                end
            end
            ST_RX: begin
                if (tb_bit_end) begin
                    r_d.shreg   = nf;
                    r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                    if (r_q.bit_cnt == 3'd7) begin
                        if (r_q.byte_cnt == '0) begin
                            if (k == KIND_WRITE_CFG || k == KIND_WRITE_WORD) begin
                                r_d.state     = ST_GAP;
                                r_d.pend_kind = k;
                                r_d.byte_cnt  = BYTE_W'(1);
                                tb_restart    = 1'b1;
                            end else if (k == KIND_NONE) begin
                                r_d.abort = 1'b1;
                                r_d.state = ST_READ;
                            end else begin
                                r_d.cmd_valid = 1'b1;
                                r_d.cmd_kind  = k;
                                r_d.frame     = {nb, {(FRAME_W-8){1'b0}}};
                                r_d.state     = ST_READ;
                                blank_start   = (k == KIND_RESET);
                            end
                        end else if (r_q.byte_cnt == BYTE_W'(FRAME_BYTES - 1)) begin
                            r_d.cmd_valid = 1'b1;
                            r_d.cmd_kind  = r_q.pend_kind;
                            r_d.frame     = nf;
                            r_d.state     = ST_READ;
                        end else begin
                            r_d.state    = ST_GAP;
                            r_d.byte_cnt = r_q.byte_cnt + 1'b1;
                            tb_restart   = 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tb_half_end) begin
                    r_d.state     = ST_WAIT;
                    r_d.from_read = 1'b0;
                    r_d.wdog      = '0;
                    r_d.low_run   = '0;
                    tb_restart    = 1'b1;
                end
            end
            default: r_d.state = ST_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.state     <= ST_READ;
            r_q.pend_kind <= KIND_NONE;
            r_q.cmd_kind  <= KIND_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mod_on    = (r_q.state == ST_WAIT) || ((r_q.state == ST_RX) && tb_second_half);
    assign cmd_valid = r_q.cmd_valid;
    assign cmd_kind  = r_q.cmd_kind;
    assign cmd_frame = r_q.frame[31:0];
    assign abort     = r_q.abort;
    assign timeout   = r_q.timeout;

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, abort, timeout})) else $error("strobes overlap"); // R7

    AST_WDOG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT) |-> (r_q.wdog < wd_lim)) else $error("wait overran"); // R3

    AST_NO_ARM_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        blank_active |-> !env_arm) else $error("armed while blanked"); // R11

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.state == ST_RX) |-> $past(!fld_hi)) else $error("rx without low"); // R4

    AST_SAMPLE_LOAD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RX && tb_bit_end) |-> mod_on) else $error("sample with load off"); // R5

    AST_WRITE_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == KIND_WRITE_WORD) |-> (cmd_frame[31:28] == OP_WRITE_HI)) else $error("bad write op"); // R9

endmodule

// File: tb/test_envcmd_rx.sv
module test_envcmd_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_rate = 1'b1;
    logic        fld_hi = 1'b0;
    logic        mod_on, cmd_valid, abort, timeout;
    logic [2:0]  cmd_kind;
    logic [31:0] cmd_frame;

    int n_checks = 0, n_fail = 0;
    int n_cmd = 0, n_abort = 0, n_to = 0, n_rise = 0;
    int bit_len = 32;
    logic [2:0]  last_kind = '0;
    logic [31:0] last_frame = '0;
    logic        mod_prev = 1'b0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    envcmd_rx i_envcmd_rx (
        .clk(clk), .rst_n(rst_n), .half_rate(half_rate), .fld_hi(fld_hi),
        .mod_on(mod_on), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_frame(cmd_frame), .abort(abort), .timeout(timeout)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                n_cmd++;
                last_kind  = cmd_kind;
                last_frame = cmd_frame;
            end
            if (abort)   n_abort++;
            if (timeout) n_to++;
            if (mod_on && !mod_prev) n_rise++;
            mod_prev = mod_on;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int nbits);
        fld_hi = lvl;
        repeat (nbits * bit_len) @(negedge clk);
    endtask

    task automatic send_sync();
        hold(1'b1, 6);
        hold(1'b0, 3);
        hold(1'b1, 2);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit with_stop);
        hold(1'b0, 1);
        for (int i = 7; i >= 0; i--) hold(b[i], 1);
        if (with_stop) hold(1'b1, 1);
    endtask

    task automatic do_reset(input logic rate, input logic lvl);
        half_rate = rate;
        bit_len   = rate ? 32 : 64;
        fld_hi    = lvl;
        rst_n     = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_and_blank();
        int c0, a0, t0;
        do_reset(1'b1, 1'b0);
        @(negedge clk);
        check(mod_on == 1'b0, "R1 mod_on after reset", mod_on, 0);
        check(n_cmd + n_abort + n_to == 0, "R1 no strobe after reset", n_cmd + n_abort + n_to, 0);
        c0 = n_cmd; a0 = n_abort; t0 = n_to;
        hold(1'b0, 10);
        send_sync();
        send_byte(8'hA5, 1'b0);
        hold(1'b0, 5);
        check(n_cmd == c0 && n_abort == a0 && n_to == t0, "R1 command blanked after reset",
              n_cmd - c0 + n_abort - a0 + n_to - t0, 0);
        hold(1'b0, 110);
    endtask

    task automatic t_short_high();
        int c0, a0, t0;
        c0 = n_cmd; a0 = n_abort; t0 = n_to;
        hold(1'b1, 2);
        hold(1'b0, 2);
        hold(1'b1, 1);
        send_byte(8'hA5, 1'b0);
        hold(1'b1, 10);
        check(n_cmd == c0 && n_abort == a0 && n_to == t0, "R2 short high run does not arm",
              n_cmd - c0 + n_abort - a0 + n_to - t0, 0);
    endtask

    task automatic t_read_id();
        int c0, r0;
        c0 = n_cmd;
        send_sync();
        check(mod_on == 1'b1, "R5 load on while waiting for start", mod_on, 1);
        r0 = n_rise;
        send_byte(8'hA5, 1'b0);
        hold(1'b1, 2);
        check(n_cmd == c0 + 1, "R4 start found, read-ID strobe count", n_cmd - c0, 1);
        check(last_kind == 3'd2, "R7 read-ID kind", last_kind, 2);
        check(last_frame == 32'hA500_0000, "R6 simple command frame", last_frame, 32'hA500_0000);
        check(n_rise - r0 == 8, "R5 one load pulse per received bit", n_rise - r0, 8);
        check(mod_on == 1'b0, "R5 load off back in read mode", mod_on, 0);
    endtask

    task automatic t_simple(input logic [7:0] b, input logic [2:0] kind);
        int c0;
        c0 = n_cmd;
        send_sync();
        send_byte(b, 1'b0);
        hold(1'b1, 2);
        check(n_cmd == c0 + 1 && last_kind == kind, "R7 simple command kind", last_kind, kind);
    endtask

    task automatic t_unknown();
        int c0, a0;
        c0 = n_cmd; a0 = n_abort;
        send_sync();
        send_byte(8'h12, 1'b0);
        hold(1'b1, 2);
        check(n_abort == a0 + 1, "R8 unknown byte aborts", n_abort - a0, 1);
        check(n_cmd == c0, "R8 unknown byte gives no command", n_cmd - c0, 0);
    endtask

    task automatic t_write(input logic [31:0] f, input logic [2:0] kind);
        int c0;
        c0 = n_cmd;
        send_sync();
        for (int i = 3; i >= 0; i--) send_byte(f[i*8 +: 8], 1'b1);
        hold(1'b1, 2);
        check(n_cmd == c0 + 1, "R9 write frame strobe", n_cmd - c0, 1);
        check(last_kind == kind, "R7 write kind", last_kind, kind);
        check(last_frame == f, "R9 write frame content", last_frame, f);
    endtask

    task automatic t_gap_timeout();
        int c0, t0;
        c0 = n_cmd; t0 = n_to;
        send_sync();
        send_byte(8'hD3, 1'b1);
        hold(1'b1, 4);
        check(n_to == t0 + 1, "R10 inter-byte timeout", n_to - t0, 1);
        check(n_cmd == c0, "R10 no command after gap timeout", n_cmd - c0, 0);
        t_simple(8'hA5, 3'd2);
        check(n_cmd == c0 + 1, "R10 no blanking after gap timeout", n_cmd - c0, 1);
    endtask

    task automatic t_sync_watchdog();
        int c0, t0;
        c0 = n_cmd; t0 = n_to;
        send_sync();
        hold(1'b1, 10);
        check(n_to == t0 + 1, "R3 post-envelope watchdog timeout", n_to - t0, 1);
        send_sync();
        send_byte(8'hA5, 1'b0);
        hold(1'b1, 2);
        check(n_cmd == c0, "R11 blanked after watchdog", n_cmd - c0, 0);
        hold(1'b1, 130);
        t_simple(8'hA5, 3'd2);
        check(n_cmd == c0 + 1, "R11 accepted after blank window", n_cmd - c0, 1);
    endtask

    task automatic t_reset_cmd();
        int c0;
        c0 = n_cmd;
        t_simple(8'hA0, 3'd1);
        send_sync();
        send_byte(8'hA5, 1'b0);
        hold(1'b1, 2);
        check(n_cmd == c0 + 1, "R11 blanked after reset command", n_cmd - c0, 1);
        hold(1'b1, 125);
        t_simple(8'hF0, 3'd3);
        check(n_cmd == c0 + 2, "R11 accepted after reset blank", n_cmd - c0, 2);
    endtask

    task automatic t_slow_rate();
        int c0;
        do_reset(1'b0, 1'b1);
        hold(1'b1, 135);
        c0 = n_cmd;
        send_sync();
        send_byte(8'hA5, 1'b0);
        hold(1'b1, 2);
        check(n_cmd == c0 + 1 && last_kind == 3'd2, "R12 command at 64 clocks per bit", last_kind, 2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset_and_blank();
        t_short_high();
        t_read_id();
        t_simple(8'hF0, 3'd3);
        t_unknown();
        t_write(32'hC5D2_2D20, 3'd5);
        t_write(32'hD302_552F, 3'd4);
        t_write(32'hCF00_FF01, 3'd5);
        t_gap_timeout();
        t_sync_watchdog();
        t_reset_cmd();
        t_slow_rate();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule